// File: doc/BRIEF.md
# General-purpose I/O port controller

This block is the pin-control register file of a small 8-bit microcontroller. It has eight ports of eight bit positions each. For every pin it holds an output latch and direction state, and it has two pull-resistor control registers. Software reaches all of it through a simple synchronous register interface with an 8-bit address and 8-bit data. Writes take effect at the clock edge on which `wr_en` is sampled high. Reads are combinational from `addr`, and a read has no side effects.

Toward the pads the block drives, for each of its 64 pin positions, an output value, an output enable, a pull-up enable and a pull-down enable. It also samples the pad input through a two-flop synchronizer. The ports come in three kinds:

- Ports 2, 5, 6 and 7, and pins 1 to 7 of port 4, have a direction bit for each pin.
- Ports 0 and 1 have a single direction bit that sets all eight pins at once.
- Port 3 and pin 0 of port 4 are input-only.

Ports 6 and 7 implement only bit positions 0 and 1. Their upper positions are absent: they never drive, never pull and read as 0.

The pull registers enable grouped pull resistors. Each group has a fixed pull-up or pull-down polarity. A pull enable is forced off on any pin that is currently driving.

Address map (n = port number 0..7): the data register of port n is at 2n and its direction register is at 2n+1. Pull register A is at 0x16 and pull register B is at 0x17. Every other address reads 0 and ignores writes. Pin bit b of port n is pad index 8n+b.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every pad output, output enable, pull-up and pull-down enable is 0, and the direction and pull registers read back 0.
- R2: On a port with a direction bit per pin (2, 5, 6, 7, and port 4 bits 1..7), writing 1 to a bit of the direction register at 2n+1 makes that pin drive its output latch value (enable 1), and writing 0 makes it an input. Bit positions 2..7 of ports 6 and 7 never drive and read back 0 from the direction register.
- R3: On ports 0 and 1, bit 0 of the direction register sets the enable of all eight pins together. Bits 1..7 of that register are ignored and read back 0.
- R4: Port 3 and port 4 bit 0 never drive their pads, and writes to their data or direction bits have no effect. The port 3 direction register and port 4 direction bit 0 read back 0. Reading those pins returns the synchronized pad level.
- R5: Reading the data register of a port returns the output latch for every pin configured as output, regardless of the pad level.
- R6: Reading the data register returns the pad level for every pin configured as input. The value is delayed by a two-flop synchronizer, so a pad change becomes visible on a read after the second rising clock edge.
- R7: Writing the data register of a pin configured as input updates only its latch. The pad stays undriven and reads still return the pad level. The latch value is read back once the pin is made an output.
- R8: Pull register A (0x16) enables these groups: bit 0 pull-down on port 0, bit 1 pull-down on port 1, bit 2 pull-up on port 2, bit 3 pull-down on port 3, and bit 4 pull-up on port 7 bits 0..1. A value of 1 enables the group.
- R9: Pull register B (0x17) enables pull-ups on these groups: bit 0 on port 4 bits 1..3, bit 1 on port 4 bits 4..7, bit 2 on port 5 bits 0..3, bit 3 on port 5 bits 4..7, and bit 4 on port 6 bits 0..1.
- R10: No pin configured as output has its pull-up or pull-down enable set, whatever the pull registers hold. The pull enable returns when the pin becomes an input again.
- R11: Bits 5..7 of both pull registers read back 0, and port 4 bit 0 never receives a pull enable.
- R12: Addresses 0x10..0x15 and 0x18..0xFF read 0, and writes to them change no register or pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pad_in | input | 64 | Pad input levels, index 8n+b |
| pad_out | output | 64 | Pad output values (the output latches) |
| pad_oe | output | 64 | Pad output enables |
| pad_pu | output | 64 | Pad pull-up enables |
| pad_pd | output | 64 | Pad pull-down enables |

## Verification
A register write takes effect at the rising edge where `wr_en` is sampled. Pad enables, pad values, pull enables and read data that depend on it are therefore due just after that edge. The bench samples them at the following falling edge. A pad input change passes two flops before reaching `rdata`. The bench changes the pad at a falling edge, checks that the old value still reads one falling edge later, and expects the new value one falling edge after that. Reads are combinational, so each read check sets `addr` at a falling edge and samples a moment later, with no clock edge in between.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PW     = 8;
    localparam int NPORT  = 8;
    localparam int NPIN   = PW * NPORT;
    localparam int AW     = 8;
    localparam int ASEL_W = $clog2(NPORT);

    localparam logic [AW-1:0] PULL_A_ADDR = 8'h16;
    localparam logic [AW-1:0] PULL_B_ADDR = 8'h17;
    localparam logic [PW-1:0] PULL_MASK   = 8'h1F;

    typedef enum logic [1:0] {
        DIR_PIN  = 2'd0,
        DIR_PORT = 2'd1,
        DIR_NONE = 2'd2
    } dir_kind_e;

    function automatic dir_kind_e port_kind(input int p);
        if (p == 0 || p == 1) return DIR_PORT;
        if (p == 3)           return DIR_NONE;
        return DIR_PIN;
    endfunction

    // bit positions that exist on the port
    function automatic logic [PW-1:0] port_present(input int p);
        if (p == 6 || p == 7) return 8'h03;
        return 8'hFF;
    endfunction

    // bit positions that are able to drive their pad
    function automatic logic [PW-1:0] port_drivable(input int p);
        if (p == 3) return 8'h00;
        if (p == 4) return 8'hFE;
        return port_present(p);
    endfunction

    function automatic int pin_idx(input int p, input int b);
        return p * PW + b;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter dir_kind_e       KIND    = DIR_PIN,
    parameter logic [PW-1:0]   PRESENT = 8'hFF,
    parameter logic [PW-1:0]   DRV     = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_we,
    input  logic          dir_we,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pin_sync,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] rd_data,
    output logic [PW-1:0] rd_dir
);

    localparam logic [PW-1:0] DIR_STORE =
        (KIND == DIR_PIN)  ? DRV :
        (KIND == DIR_PORT) ? {{(PW-1){1'b0}}, 1'b1} : '0;

    logic [PW-1:0] latch_q;
    logic [PW-1:0] dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (data_we) begin
            latch_q <= wdata & DRV;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_we) begin
            dir_q <= wdata & DIR_STORE;
        end
    end

    generate
        if (KIND == DIR_PORT) begin : g_whole
            assign pin_oe = {PW{dir_q[0]}} & DRV;
        end else begin : g_each
            assign pin_oe = dir_q;
        end
    endgenerate

    assign pin_out = latch_q;
    assign rd_dir  = dir_q;
    assign rd_data = ((latch_q & pin_oe) | (pin_sync & ~pin_oe)) & PRESENT;

endmodule

// File: rtl/gpio_pull.sv
module gpio_pull
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_a,
    input  logic            we_b,
    input  logic [PW-1:0]   wdata,
    input  logic [NPIN-1:0] oe,
    output logic [NPIN-1:0] pu,
    output logic [NPIN-1:0] pd,
    output logic [PW-1:0]   rd_a,
    output logic [PW-1:0]   rd_b
);

    logic [PW-1:0]   a_q, b_q;
    logic [NPIN-1:0] pu_req, pd_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (we_a) a_q <= wdata & PULL_MASK;
            if (we_b) b_q <= wdata & PULL_MASK;
        end
    end

    always_comb begin
        pu_req = '0;
        pd_req = '0;
        // register A: mixed polarity, one whole group per bit
        pd_req[pin_idx(0, 0) +: 8] = {8{a_q[0]}};
        pd_req[pin_idx(1, 0) +: 8] = {8{a_q[1]}};
        pu_req[pin_idx(2, 0) +: 8] = {8{a_q[2]}};
        pd_req[pin_idx(3, 0) +: 8] = {8{a_q[3]}};
        pu_req[pin_idx(7, 0) +: 2] = {2{a_q[4]}};
        // register B: pull-ups only; port 4 bit 0 has no control
        pu_req[pin_idx(4, 1) +: 3] = {3{b_q[0]}};
        pu_req[pin_idx(4, 4) +: 4] = {4{b_q[1]}};
        pu_req[pin_idx(5, 0) +: 4] = {4{b_q[2]}};
        pu_req[pin_idx(5, 4) +: 4] = {4{b_q[3]}};
        pu_req[pin_idx(6, 0) +: 2] = {2{b_q[4]}};
    end

    assign pu   = pu_req & ~oe;
    assign pd   = pd_req & ~oe;
    assign rd_a = a_q;
    assign rd_b = b_q;

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [PW-1:0]   wdata,
    output logic [PW-1:0]   rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] pad_pd
);

    localparam logic [AW-1:0] PORT_SPAN = AW'(2 * NPORT);

    logic [NPIN-1:0] pin_sync;
    logic [PW-1:0]   port_rd  [NPORT];
    logic [PW-1:0]   port_dir [NPORT];
    logic [PW-1:0]   pull_rd_a, pull_rd_b;

    gpio_sync #(
        .W      (NPIN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (pin_sync)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            localparam logic [AW-1:0] DATA_ADDR = AW'(2 * p);
            localparam logic [AW-1:0] DIR_ADDR  = AW'(2 * p + 1);

            gpio_port #(
                .KIND    (port_kind(p)),
                .PRESENT (port_present(p)),
                .DRV     (port_drivable(p))
            ) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .data_we  (wr_en && (addr == DATA_ADDR)),
                .dir_we   (wr_en && (addr == DIR_ADDR)),
                .wdata    (wdata),
                .pin_sync (pin_sync[p*PW +: PW]),
                .pin_out  (pad_out[p*PW +: PW]),
                .pin_oe   (pad_oe[p*PW +: PW]),
                .rd_data  (port_rd[p]),
                .rd_dir   (port_dir[p])
            );
        end
    endgenerate

    gpio_pull u_pull (
        .clk   (clk),
        .rst_n (rst_n),
        .we_a  (wr_en && (addr == PULL_A_ADDR)),
        .we_b  (wr_en && (addr == PULL_B_ADDR)),
        .wdata (wdata),
        .oe    (pad_oe),
        .pu    (pad_pu),
        .pd    (pad_pd),
        .rd_a  (pull_rd_a),
        .rd_b  (pull_rd_b)
    );

    always_comb begin
        rdata = '0;
        if (addr < PORT_SPAN) begin
            rdata = addr[0] ? port_dir[addr[ASEL_W:1]] : port_rd[addr[ASEL_W:1]];
        end else if (addr == PULL_A_ADDR) begin
            rdata = pull_rd_a;
        end else if (addr == PULL_B_ADDR) begin
            rdata = pull_rd_b;
        end
    end

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [PW-1:0]   wdata,
    input logic [PW-1:0]   rdata,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_pu,
    input logic [NPIN-1:0] pad_pd
);

    // R10: pulls never active on a driving pin
    a_r10_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu | pad_pd) & pad_oe) == '0);

    // R3: ports 0 and 1 switch direction as a whole
    a_r3_whole_port_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[7:0] == 8'h00 || pad_oe[7:0] == 8'hFF) &&
        (pad_oe[15:8] == 8'h00 || pad_oe[15:8] == 8'hFF));

    // R4: input-only pins never drive
    a_r4_input_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[31:24] == 8'h00 && !pad_oe[32] && pad_out[31:24] == 8'h00 && !pad_out[32]);

    // R2: a port 2 direction write sets its enables on the next cycle
    a_r2_dir_write_p2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h05) |=> (pad_oe[23:16] == $past(wdata)));

    // R5: reading port 2 returns the latch on output pins
    a_r5_read_latch_p2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h04) |-> (((rdata ^ pad_out[23:16]) & pad_oe[23:16]) == 8'h00));

    // R11: unused pull bits read as zero
    a_r11_pull_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == PULL_A_ADDR || addr == PULL_B_ADDR) |-> (rdata[7:5] == 3'b000));

    // R11: port 4 bit 0 has no pull control
    a_r11_p40_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_pu[32] && !pad_pd[32]);

    // R12: unmapped addresses read zero
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 8'h18 || (addr >= 8'h10 && addr < 8'h16)) |-> (rdata == 8'h00));

endmodule

bind gpio_ctrl gpio_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu),
    .pad_pd  (pad_pd)
);

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_out, pad_oe, pad_pu, pad_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu),
        .pad_pd  (pad_pd)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pad_oe", pad_oe, 64'h0);
        check("R1 pad_pu", pad_pu, 64'h0);
        check("R1 pad_pd", pad_pd, 64'h0);
        check("R1 pad_out", pad_out, 64'h0);
        rd(8'h05, v); check("R1 dir p2", {56'h0, v}, 64'h0);
        rd(8'h01, v); check("R1 dir p0", {56'h0, v}, 64'h0);
        rd(8'h16, v); check("R1 pull a", {56'h0, v}, 64'h0);
        rd(8'h17, v); check("R1 pull b", {56'h0, v}, 64'h0);
    endtask

    task automatic t_per_pin();
        logic [7:0] v;
        wr(8'h04, 8'hA5);
        check("R7 oe stays off", pad_oe, 64'h0);
        rd(8'h04, v); check("R7 input reads pad", {56'h0, v}, 64'h0);
        wr(8'h05, 8'h0F);
        check("R2 p2 enables", pad_oe, 64'h0000_0000_000F_0000);
        check("R2 p2 drive value", {56'h0, pad_out[23:16]}, 64'hA5);
        @(negedge clk); pad_in[23:16] = 8'h3C;
        @(negedge clk); rd(8'h04, v); check("R6 one edge old", {56'h0, v}, 64'h05);
        @(negedge clk); rd(8'h04, v); check("R6 two edges new", {56'h0, v}, 64'h35);
        wr(8'h05, 8'hFF);
        rd(8'h04, v); check("R7 latch seen as output", {56'h0, v}, 64'hA5);
        wr(8'h05, 8'h00);
        wr(8'h0D, 8'hFF);
        check("R2 p6 enables", pad_oe, 64'h0003_0000_0000_0000);
        rd(8'h0D, v); check("R2 p6 dir read", {56'h0, v}, 64'h03);
        wr(8'h0D, 8'h00);
    endtask

    task automatic t_whole_port();
        logic [7:0] v;
        wr(8'h01, 8'hFE);
        check("R3 upper bits ignored", pad_oe, 64'h0);
        rd(8'h01, v); check("R3 upper bits read 0", {56'h0, v}, 64'h0);
        wr(8'h01, 8'h01);
        check("R3 whole port out", pad_oe, 64'h0000_0000_0000_00FF);
        rd(8'h01, v); check("R3 dir read", {56'h0, v}, 64'h01);
        wr(8'h00, 8'h5A);
        pad_in[7:0] = 8'hFF;
        @(negedge clk); @(negedge clk);
        rd(8'h00, v); check("R5 latch not pad", {56'h0, v}, 64'h5A);
        check("R5 p0 drive value", {56'h0, pad_out[7:0]}, 64'h5A);
        wr(8'h01, 8'h00);
    endtask

    task automatic t_input_only();
        logic [7:0] v;
        wr(8'h07, 8'hFF);
        wr(8'h06, 8'hFF);
        check("R4 p3 no drive", pad_oe, 64'h0);
        check("R4 p3 no value", {56'h0, pad_out[31:24]}, 64'h0);
        rd(8'h07, v); check("R4 p3 dir read", {56'h0, v}, 64'h0);
        pad_in[31:24] = 8'h96;
        @(negedge clk); @(negedge clk);
        rd(8'h06, v); check("R4 p3 reads pad", {56'h0, v}, 64'h96);
        wr(8'h09, 8'hFF);
        check("R4 p40 no enable", pad_oe, 64'h0000_00FE_0000_0000);
        rd(8'h09, v); check("R4 p4 dir read", {56'h0, v}, 64'hFE);
        wr(8'h08, 8'hFF);
        check("R4 p40 no value", {56'h0, pad_out[39:32]}, 64'hFE);
        wr(8'h09, 8'h00);
    endtask

    task automatic t_pull_a();
        logic [7:0] v;
        wr(8'h16, 8'hFF);
        rd(8'h16, v); check("R11 pull a readback", {56'h0, v}, 64'h1F);
        check("R8 pd all groups", pad_pd, 64'h0000_0000_FF00_FFFF);
        check("R8 pu all groups", pad_pu, 64'h0300_0000_00FF_0000);
        wr(8'h16, 8'h08);
        check("R8 bit3 pd p3", pad_pd, 64'h0000_0000_FF00_0000);
        check("R8 bit3 no pu", pad_pu, 64'h0);
        wr(8'h16, 8'h00);
    endtask

    task automatic t_pull_b();
        logic [7:0] v;
        wr(8'h17, 8'hFF);
        rd(8'h17, v); check("R11 pull b readback", {56'h0, v}, 64'h1F);
        check("R9 pu all groups", pad_pu, 64'h0003_FFFE_0000_0000);
        check("R9 no pd", pad_pd, 64'h0);
        wr(8'h17, 8'h04);
        check("R9 bit2 p5 low", pad_pu, 64'h0000_0F00_0000_0000);
        wr(8'h17, 8'h02);
        check("R9 bit1 p4 high", pad_pu, 64'h0000_00F0_0000_0000);
        wr(8'h17, 8'h00);
    endtask

    task automatic t_suppress();
        wr(8'h16, 8'h1F);
        wr(8'h17, 8'h1F);
        wr(8'h0B, 8'hF0);
        wr(8'h01, 8'h01);
        wr(8'h09, 8'h02);
        check("R10 pu masked", pad_pu, 64'h0303_0FFC_00FF_0000);
        check("R10 pd masked", pad_pd, 64'h0000_0000_FF00_FF00);
        check("R10 overlap", (pad_pu | pad_pd) & pad_oe, 64'h0);
        wr(8'h0B, 8'h00);
        wr(8'h01, 8'h00);
        wr(8'h09, 8'h00);
        check("R10 pd restored", pad_pd, 64'h0000_0000_FF00_FFFF);
        check("R10 pu restored", pad_pu, 64'h0303_FFFE_00FF_0000);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        logic [63:0] s_oe, s_out, s_pu, s_pd;
        wr(8'h05, 8'h33);
        s_oe = pad_oe; s_out = pad_out; s_pu = pad_pu; s_pd = pad_pd;
        wr(8'h20, 8'hFF);
        wr(8'h10, 8'hFF);
        wr(8'h18, 8'h00);
        check("R12 oe unchanged", pad_oe, s_oe);
        check("R12 out unchanged", pad_out, s_out);
        check("R12 pu unchanged", pad_pu, s_pu);
        check("R12 pd unchanged", pad_pd, s_pd);
        rd(8'h20, v); check("R12 read 0x20", {56'h0, v}, 64'h0);
        rd(8'h18, v); check("R12 read 0x18", {56'h0, v}, 64'h0);
        rd(8'h10, v); check("R12 read 0x10", {56'h0, v}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_per_pin();
        t_whole_port();
        t_input_only();
        t_pull_a();
        t_pull_b();
        t_suppress();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule